// File: doc/BRIEF.md
# Scoreboard issue controller

This block decides when decoded instructions may leave the in-order front end and enter one of four unpipelined execution units: an integer adder, a floating-point adder, a floating-point multiplier and a floating-point divider. All four units share one register file of eight registers. Each instruction names a unit type, a destination register and two source registers. The block does not compute results. It only sequences the three events of each instruction: dispatch into a unit, reading of operands, and write-back of the result.

Dispatch stays in program order. It holds when the required unit is occupied or when the destination already has an outstanding write. After dispatch, each unit waits on its own for its operands. Units may therefore read and execute out of program order. A finished result stays in its unit until no earlier instruction still has to read the old contents of the destination register. A bank of per-register producer tags and a fixed-priority write-back arbiter tie these rules together.

Top module: `sb_issue_ctrl`

## Requirements
- R1: `in_unit` selects the unit (0 integer adder, 1 FP adder, 2 FP multiplier, 3 FP divider). An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both high. Accepted instructions leave in the order they were presented, and back-to-back presentations to free units are taken on consecutive cycles.
- R2: `in_ready` is low while the selected unit holds an instruction. A unit becomes free again in the cycle after its write-back.
- R3: `in_ready` is low while the destination register has a write outstanding. It rises in the cycle after that write-back.
- R4: A unit pulses its `rd_fire` bit for one cycle when both of its sources are available. With no pending producer, this happens in the cycle after dispatch.
- R5: Operand reads do not follow program order. A later instruction whose sources are free reads before an earlier one that is still waiting.
- R6: Latencies are 1, 4, 6 and 20 cycles for units 0 to 3. Without contention, write-back comes latency+1 cycles after the operand read.
- R7: A finished result is not written back while another waiting unit has a ready, not-yet-read source naming the same register. Write-back follows in the cycle after that read.
- R8: A write-back clears the register's pending state and frees the unit. Any unit waiting on that result reads in the next cycle.
- R9: At most one write-back happens per cycle. When several units are ready, the lowest unit number wins and the others wait.
- R10: After reset, all units are free, no register is pending, and `wb_valid` and `rd_fire` are low.
- R11: During a write-back, `wb_unit` and `wb_dst` give the writing unit and its destination register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_unit | input | 2 | Unit type of the instruction |
| in_dst | input | 3 | Destination register |
| in_src1 | input | 3 | First source register |
| in_src2 | input | 3 | Second source register |
| in_ready | output | 1 | Instruction can be dispatched this cycle |
| rd_fire | output | 4 | Per-unit operand-read strobe |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_unit | output | 2 | Unit performing the write-back |
| wb_dst | output | 3 | Register being written |

## Verification
A lost or stale producer tag shows at the ports in one of two ways. If a tag is lost, a dependent instruction's `rd_fire` comes early. If a tag is stale, `in_ready` never rises or `rd_fire` never appears. Either is visible within one unit latency of the write-back that should have cleared the tag. A wrong read-ready flag shows in the cycle of the blocked write-back: the result appears while an earlier reader is still waiting, or it never appears at all. The directed scenarios therefore pin the exact cycle of every read and write-back against counts worked out from the latencies.

// File: rtl/sb_pkg.sv
// Shared constants and types for the scoreboard issue controller.
// Assumes exactly four unit slots, one per unit type.
package sb_pkg;
    localparam int NUM_UNITS = 4;
    localparam int UNIT_W    = $clog2(NUM_UNITS);

    typedef enum logic [UNIT_W-1:0] {
        U_IADD = 2'd0,
        U_FADD = 2'd1,
        U_FMUL = 2'd2,
        U_FDIV = 2'd3
    } unit_kind_e;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_EXEC = 2'd2,
        SLOT_DONE = 2'd3
    } slot_state_e;
endpackage

// File: rtl/sb_reg_status.sv
// Per-register producer tags. For each register it records whether a
// write is outstanding and which unit will perform it.
// Assumes that the set and the clear never target the same register in one
// cycle; dispatch is refused while the destination is pending.
module sb_reg_status
    import sb_pkg::*;
#(
    parameter int REG_W = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              set_i,
    input  logic [REG_W-1:0]                  set_reg_i,
    input  logic [UNIT_W-1:0]                 set_unit_i,
    input  logic                              clr_i,
    input  logic [REG_W-1:0]                  clr_reg_i,
    output logic [(1<<REG_W)-1:0]             pend_vld_o,
    output logic [(1<<REG_W)-1:0][UNIT_W-1:0] pend_unit_o
);
    localparam int NUM_REGS = 1 << REG_W;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        // Track the outstanding writer of register r.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_vld_o[r]  <= 1'b0;
                pend_unit_o[r] <= '0;
            end else if (set_i && set_reg_i == REG_W'(r)) begin
                pend_vld_o[r]  <= 1'b1;
                pend_unit_o[r] <= set_unit_i;
            end else if (clr_i && clr_reg_i == REG_W'(r)) begin
                pend_vld_o[r]  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sb_fu_slot.sv
// Status of one unpipelined unit: idle, waiting for operands, executing
// for LAT cycles, or holding a finished result until write-back.
// Assumes that dispatch is only asserted while the slot is idle, and that a
// write-back broadcast naming this slot only occurs while it is done.
module sb_fu_slot
    import sb_pkg::*;
#(
    parameter int REG_W = 3,
    parameter int LAT   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_i,
    input  logic [REG_W-1:0]  dst_i,
    input  logic [REG_W-1:0]  src1_i,
    input  logic [REG_W-1:0]  src2_i,
    input  logic              q1_vld_i,
    input  logic [UNIT_W-1:0] q1_unit_i,
    input  logic              q2_vld_i,
    input  logic [UNIT_W-1:0] q2_unit_i,
    input  logic              wb_valid_i,
    input  logic [UNIT_W-1:0] wb_unit_i,
    input  logic              war_block_i,
    input  logic              grant_i,
    output logic              busy_o,
    output logic              waiting_o,
    output logic              rd_fire_o,
    output logic              wb_req_o,
    output logic [REG_W-1:0]  dst_o,
    output logic [REG_W-1:0]  src1_o,
    output logic [REG_W-1:0]  src2_o,
    output logic              r1_o,
    output logic              r2_o
);
    localparam int CNT_W = $clog2(LAT + 1);

    slot_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic [UNIT_W-1:0] q1, q2;

    // Operand-availability at dispatch, including a same-cycle write-back.
    logic r1_at_disp, r2_at_disp;
    always_comb begin
        r1_at_disp = !q1_vld_i || (wb_valid_i && wb_unit_i == q1_unit_i);
        r2_at_disp = !q2_vld_i || (wb_valid_i && wb_unit_i == q2_unit_i);
    end

    // Status outputs derived from the slot state.
    always_comb begin
        busy_o    = (state != SLOT_IDLE);
        waiting_o = (state == SLOT_WAIT);
        rd_fire_o = (state == SLOT_WAIT) && r1_o && r2_o;
        wb_req_o  = (state == SLOT_DONE) && !war_block_i;
    end

    // Slot state machine with operand wake-up and latency count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SLOT_IDLE;
            cnt    <= '0;
            q1     <= '0;
            q2     <= '0;
            r1_o   <= 1'b0;
            r2_o   <= 1'b0;
            dst_o  <= '0;
            src1_o <= '0;
            src2_o <= '0;
        end else begin
            case (state)
                SLOT_IDLE: begin
                    if (disp_i) begin
                        state  <= SLOT_WAIT;
                        dst_o  <= dst_i;
                        src1_o <= src1_i;
                        src2_o <= src2_i;
                        q1     <= q1_unit_i;
                        q2     <= q2_unit_i;
                        r1_o   <= r1_at_disp;
                        r2_o   <= r2_at_disp;
                    end
                end
                SLOT_WAIT: begin
                    if (rd_fire_o) begin
                        state <= SLOT_EXEC;
                        cnt   <= CNT_W'(LAT);
                        r1_o  <= 1'b0;
                        r2_o  <= 1'b0;
                    end else begin
                        if (!r1_o && wb_valid_i && wb_unit_i == q1) r1_o <= 1'b1;
                        if (!r2_o && wb_valid_i && wb_unit_i == q2) r2_o <= 1'b1;
                    end
                end
                SLOT_EXEC: begin
                    cnt <= cnt - CNT_W'(1);
                    if (cnt == CNT_W'(1)) state <= SLOT_DONE;
                end
                SLOT_DONE: begin
                    if (grant_i) state <= SLOT_IDLE;
                end
                default: state <= SLOT_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sb_wb_arbiter.sv
// Fixed-priority write-back arbiter: the lowest-numbered requester wins.
// Assumes nothing about the request pattern.
module sb_wb_arbiter
    import sb_pkg::*;
#(
    parameter int N = NUM_UNITS
) (
    input  logic [N-1:0]         req_i,
    output logic [N-1:0]         grant_o,
    output logic                 valid_o,
    output logic [$clog2(N)-1:0] idx_o
);
    // Scan from the top so that the lowest index is written last.
    always_comb begin
        valid_o = |req_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = ($clog2(N))'(i);
        end
        grant_o = '0;
        if (valid_o) grant_o[idx_o] = 1'b1;
    end
endmodule

// File: rtl/sb_issue_ctrl.sv
// Scoreboard issue controller. Dispatches in order to four unpipelined
// units, blocking on structural and write-after-write hazards. It lets
// each unit read once its sources are ready, and holds results until no
// write-after-read hazard remains.
// Assumes one instruction is presented per cycle and held until accepted.
module sb_issue_ctrl
    import sb_pkg::*;
#(
    parameter int REG_W    = 3,
    parameter int LAT_IADD = 1,
    parameter int LAT_FADD = 4,
    parameter int LAT_FMUL = 6,
    parameter int LAT_FDIV = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [UNIT_W-1:0]    in_unit,
    input  logic [REG_W-1:0]     in_dst,
    input  logic [REG_W-1:0]     in_src1,
    input  logic [REG_W-1:0]     in_src2,
    output logic                 in_ready,
    output logic [NUM_UNITS-1:0] rd_fire,
    output logic                 wb_valid,
    output logic [UNIT_W-1:0]    wb_unit,
    output logic [REG_W-1:0]     wb_dst
);
    localparam int NUM_REGS = 1 << REG_W;

    logic [NUM_REGS-1:0]              pend_vld;
    logic [NUM_REGS-1:0][UNIT_W-1:0]  pend_unit;
    logic [NUM_UNITS-1:0]             unit_busy, unit_wait, unit_req, unit_grant;
    logic [NUM_UNITS-1:0]             unit_r1, unit_r2, war_block;
    logic [NUM_UNITS-1:0][REG_W-1:0]  unit_dst, unit_src1, unit_src2;
    logic                             disp_fire;

    // Dispatch gate: the unit must be free and the destination unclaimed.
    always_comb begin
        in_ready  = !unit_busy[in_unit] && !pend_vld[in_dst];
        disp_fire = in_valid && in_ready;
        wb_dst    = unit_dst[wb_unit];
    end

    // A finished unit is held while a waiting unit still needs the old value.
    always_comb begin
        war_block = '0;
        for (int f = 0; f < NUM_UNITS; f++) begin
            for (int g = 0; g < NUM_UNITS; g++) begin
                if (unit_wait[g] &&
                    ((unit_r1[g] && unit_src1[g] == unit_dst[f]) ||
                     (unit_r2[g] && unit_src2[g] == unit_dst[f])))
                    war_block[f] = 1'b1;
            end
        end
    end

    sb_reg_status #(.REG_W(REG_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (disp_fire),
        .set_reg_i   (in_dst),
        .set_unit_i  (in_unit),
        .clr_i       (wb_valid),
        .clr_reg_i   (wb_dst),
        .pend_vld_o  (pend_vld),
        .pend_unit_o (pend_unit)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        localparam int SLOT_LAT = (u == int'(U_IADD)) ? LAT_IADD :
                                  (u == int'(U_FADD)) ? LAT_FADD :
                                  (u == int'(U_FMUL)) ? LAT_FMUL : LAT_FDIV;
        sb_fu_slot #(.REG_W(REG_W), .LAT(SLOT_LAT)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .disp_i      (disp_fire && in_unit == UNIT_W'(u)),
            .dst_i       (in_dst),
            .src1_i      (in_src1),
            .src2_i      (in_src2),
            .q1_vld_i    (pend_vld[in_src1]),
            .q1_unit_i   (pend_unit[in_src1]),
            .q2_vld_i    (pend_vld[in_src2]),
            .q2_unit_i   (pend_unit[in_src2]),
            .wb_valid_i  (wb_valid),
            .wb_unit_i   (wb_unit),
            .war_block_i (war_block[u]),
            .grant_i     (unit_grant[u]),
            .busy_o      (unit_busy[u]),
            .waiting_o   (unit_wait[u]),
            .rd_fire_o   (rd_fire[u]),
            .wb_req_o    (unit_req[u]),
            .dst_o       (unit_dst[u]),
            .src1_o      (unit_src1[u]),
            .src2_o      (unit_src2[u]),
            .r1_o        (unit_r1[u]),
            .r2_o        (unit_r2[u])
        );
    end

    sb_wb_arbiter #(.N(NUM_UNITS)) u_arb (
        .req_i   (unit_req),
        .grant_o (unit_grant),
        .valid_o (wb_valid),
        .idx_o   (wb_unit)
    );
endmodule

// File: rtl/sb_issue_ctrl_chk.sv
// Checker for the scoreboard issue controller: relates dispatch, operand
// reads and write-back to the per-unit busy state over time.
// Assumes it is bound into sb_issue_ctrl.
module sb_issue_ctrl_chk
    import sb_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [UNIT_W-1:0]    in_unit,
    input logic [NUM_UNITS-1:0] rd_fire,
    input logic                 wb_valid,
    input logic [UNIT_W-1:0]    wb_unit,
    input logic [NUM_UNITS-1:0] unit_busy
);
    // R1: an accepted instruction occupies its unit from the next cycle.
    p_dispatch_claims_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> unit_busy[$past(in_unit)]);

    // R11: only an occupied unit can write back.
    p_wb_from_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> unit_busy[wb_unit]);

    // R8: the writing unit is free in the cycle after its write-back.
    p_wb_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !unit_busy[$past(wb_unit)]);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
        // R4: an operand read is a single-cycle pulse.
        p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
            rd_fire[u] |=> !rd_fire[u]);

        // R4: only an occupied unit reads operands.
        p_read_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
            rd_fire[u] |-> unit_busy[u]);
    end
endmodule

bind sb_issue_ctrl sb_issue_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_unit   (in_unit),
    .rd_fire   (rd_fire),
    .wb_valid  (wb_valid),
    .wb_unit   (wb_unit),
    .unit_busy (unit_busy)
);

// File: tb/sb_issue_ctrl_tb.sv
// Directed bench for the scoreboard issue controller. A monitor logs the
// cycle of every operand read and write-back; each scenario task checks
// those logs against cycle counts derived from the requirements.
module sb_issue_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_unit = '0;
    logic [2:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic       in_ready;
    logic [3:0] rd_fire;
    logic       wb_valid;
    logic [1:0] wb_unit;
    logic [2:0] wb_dst;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit finished = 1'b0;
    int rd_cyc[4];
    int wb_cyc[4];
    int wb_reg[4];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    sb_issue_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_unit  (in_unit),
        .in_dst   (in_dst),
        .in_src1  (in_src1),
        .in_src2  (in_src2),
        .in_ready (in_ready),
        .rd_fire  (rd_fire),
        .wb_valid (wb_valid),
        .wb_unit  (wb_unit),
        .wb_dst   (wb_dst)
    );

    // Log read and write-back cycles mid-cycle.
    always @(negedge clk) begin
        #2;
        for (int u = 0; u < 4; u++) if (rd_fire[u]) rd_cyc[u] = cyc;
        if (wb_valid) begin
            wb_cyc[wb_unit] = cyc;
            wb_reg[wb_unit] = int'(wb_dst);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        for (int u = 0; u < 4; u++) begin
            rd_cyc[u] = -1;
            wb_cyc[u] = -1;
            wb_reg[u] = -1;
        end
    endtask

    // Present one instruction at a negedge and hold it until accepted.
    task automatic issue(input int unit, input int dst, input int s1, input int s2,
                         output int acc, output bit stalled);
        in_valid = 1'b1;
        in_unit  = unit[1:0];
        in_dst   = dst[2:0];
        in_src1  = s1[2:0];
        in_src2  = s2[2:0];
        #1;
        stalled = !in_ready;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        acc = cyc;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        in_valid = 1'b1;
        in_unit  = 2'd3;
        repeat (3) @(negedge clk);
        #1;
        check("R10 wb_valid in reset", int'(wb_valid), 0);
        check("R10 rd_fire in reset", int'(rd_fire), 0);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        #1;
        check("R10 ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_latency();
        int d0, d1, d2, d3;
        bit s;
        clear_logs();
        issue(0, 1, 5, 6, d0, s);
        issue(1, 2, 5, 6, d1, s);
        issue(2, 3, 5, 6, d2, s);
        issue(3, 4, 5, 6, d3, s);
        idle(30);
        check("R1 in-order back-to-back", d3 - d0, 3);
        check("R4 read after dispatch", rd_cyc[0], d0 + 1);
        check("R4 fdiv read", rd_cyc[3], d3 + 1);
        check("R6 iadd latency", wb_cyc[0], d0 + 3);
        check("R6 fadd latency", wb_cyc[1], d1 + 6);
        check("R6 fmul latency", wb_cyc[2], d2 + 8);
        check("R6 fdiv latency", wb_cyc[3], d3 + 22);
        check("R11 wb_dst iadd", wb_reg[0], 1);
        check("R11 wb_dst fdiv", wb_reg[3], 4);
    endtask

    task automatic t_structural();
        int d0, d1;
        bit s;
        clear_logs();
        issue(3, 1, 5, 6, d0, s);
        issue(3, 2, 5, 6, d1, s);
        check("R2 busy unit stalls", int'(s), 1);
        check("R2 dispatch after wb", d1, d0 + 23);
        idle(30);
        check("R2 second fdiv wb", wb_cyc[3], d1 + 22);
        check("R11 second fdiv dst", wb_reg[3], 2);
    endtask

    task automatic t_waw();
        int d0, d1;
        bit s;
        clear_logs();
        issue(2, 4, 5, 6, d0, s);
        issue(0, 4, 5, 6, d1, s);
        check("R3 pending dst stalls", int'(s), 1);
        check("R3 dispatch after wb", d1, d0 + 9);
        idle(20);
        check("R3 fmul wb", wb_cyc[2], d0 + 8);
        check("R3 iadd wb", wb_cyc[0], d1 + 3);
    endtask

    task automatic t_raw();
        int d0, d1, d2;
        bit s;
        clear_logs();
        issue(2, 5, 1, 2, d0, s);
        issue(0, 6, 5, 0, d1, s);
        issue(3, 7, 1, 2, d2, s);
        idle(30);
        check("R8 dependent read after wb", rd_cyc[0], d0 + 9);
        check("R8 dependent wb", wb_cyc[0], d0 + 11);
        check("R5 independent read", rd_cyc[3], d2 + 1);
        check("R5 out-of-order read", int'(rd_cyc[3] < rd_cyc[0]), 1);
    endtask

    task automatic t_war();
        int d0, d1, d2;
        bit s;
        clear_logs();
        issue(3, 2, 0, 0, d0, s);
        issue(1, 3, 2, 4, d1, s);
        issue(0, 4, 5, 5, d2, s);
        idle(35);
        check("R7 reader reads after producer", rd_cyc[1], d0 + 23);
        check("R7 held result waits for read", wb_cyc[0], d0 + 24);
        check("R7 reader wb", wb_cyc[1], d0 + 28);
    endtask

    task automatic t_priority();
        int d0, d1;
        bit s;
        clear_logs();
        issue(2, 1, 5, 6, d0, s);
        idle(1);
        issue(1, 2, 5, 6, d1, s);
        idle(15);
        check("R9 lower unit first", wb_cyc[1], d0 + 8);
        check("R9 higher unit deferred", wb_cyc[2], d0 + 9);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        clear_logs();
        @(negedge clk);
        t_reset();
        t_latency();
        t_structural();
        t_waw();
        t_raw();
        t_war();
        t_priority();
        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung scenario counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (R1..R11 run): actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule